// File: doc/BRIEF.md
# Instrument Interface Test Data Register

This block is a scan-accessible data register that sits between one embedded instrument and a serial scan network. A network controller steers it through four operations on the scan clock: capture (load the instrument's response bits into the serial stage), shift (move the serial stage one position from scan input toward scan output), update (copy the serial stage into a parallel latch that drives the instrument's control inputs) and hold. The length and the access type of every bit are parameters, so one register can be sized to its instrument.

The parallel latch is separate from the serial stage. Controls such as run, enable and a control word therefore stay steady while a new pattern is shifted in, and they change only when an update is issued. Each bit is read-only (response only, no latch), write-only (latch only; capture reloads the latch value) or read-write (both). The operation decoder has four named states, HOLD, CAPTURE, SHIFT and UPDATE. In each cycle it enters CAPTURE, SHIFT or UPDATE only when select is high and exactly one of the matching enables is high. In every other case it falls back to HOLD.

Top module: `tdr_instr_if`

## Requirements
- R1: While `rst_n` is low, asynchronously and regardless of the clock, the serial stage clears to zero, `scan_out` goes to 0 and `ctrl_out` takes the reset value. The default reset value is 8'h28: bits 0 (run) and 1 (enable) are 0 and the control word in bits 5..2 is 4'b1010. Read-only bits read 0.
- R2: In SHIFT (select high, only `shift_en` high), the serial stage moves one place toward bit 0 on the rising edge. `scan_in` enters the top bit, so the register is read out least significant bit first.
- R3: `scan_out` presents serial bit 0 and changes only on the falling clock edge. Just after a rising edge it still shows the value from before that edge.
- R4: `ctrl_out` changes only in UPDATE. It is unchanged through any number of SHIFT, CAPTURE or HOLD cycles.
- R5: In UPDATE, writable bits take the serial stage value. These are the write-only bits 0..1 and the read-write bits 2..5 in the default layout. Read-only bits (7..6) have no latch, and their `ctrl_out` bits stay 0.
- R6: In CAPTURE, readable bits (2..7) load `resp_in`, while write-only bits (0..1) load their current `ctrl_out` value.
- R7: With select low, no enable or `scan_in` value changes the serial stage, `ctrl_out` or `scan_out`.
- R8: With select high and more than one of capture, shift and update enabled, the cycle is HOLD. Nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous global reset, active low |
| sel | input | 1 | Register selected in the scan path |
| capture_en | input | 1 | Capture request |
| shift_en | input | 1 | Shift request |
| update_en | input | 1 | Update request |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out, falling-edge retimed |
| resp_in | input | LEN | Instrument response bits |
| ctrl_out | output | LEN | Instrument control bits from the update latch |

## Verification
The bench builds the register with its default parameters: 8 bits, with the write mask 8'h3F, the read mask 8'hFC and the reset value 8'h28. This single instance holds all three access types side by side. Write-only, read-write and read-only bits can therefore be told apart in one captured word and one update. Eight bits are few enough that every shifted bit is observed at `scan_out`. A full pattern-in, update and capture-out cycle completes in under thirty clocks.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2,
        OP_UPDATE  = 2'd3
    } tdr_op_e;
endpackage

// File: rtl/tdr_op_decode.sv
module tdr_op_decode
    import tdr_pkg::*;
(
    input  logic    sel_i,
    input  logic    cap_i,
    input  logic    shf_i,
    input  logic    upd_i,
    output tdr_op_e op_o
);
    tdr_op_e op_next;

    // State selection: only a single enable under select leaves HOLD
    always_comb begin
        op_next = OP_HOLD;
        if (sel_i) begin
            unique case ({cap_i, shf_i, upd_i})
                3'b100:  op_next = OP_CAPTURE;
                3'b010:  op_next = OP_SHIFT;
                3'b001:  op_next = OP_UPDATE;
                default: op_next = OP_HOLD;
            endcase
        end
    end

    // Output process
    always_comb begin
        op_o = op_next;
    end
endmodule

// File: rtl/tdr_shift_stage.sv
module tdr_shift_stage
    import tdr_pkg::*;
#(
    parameter int LEN = 8
) (
    input  logic           tck,
    input  logic           rst_n,
    input  tdr_op_e        op_i,
    input  logic           si_i,
    input  logic [LEN-1:0] cap_d_i,
    output logic [LEN-1:0] sh_q
);
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            case (op_i)
                OP_CAPTURE: sh_q <= cap_d_i;
                OP_SHIFT:   sh_q <= {si_i, sh_q[LEN-1:1]};
                default:    sh_q <= sh_q;
            endcase
        end
    end

    p_capture_load_r6: assert property (@(posedge tck) disable iff (!rst_n)
        (op_i == OP_CAPTURE) |=> (sh_q == $past(cap_d_i)));

    p_shift_move_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (op_i == OP_SHIFT) |=> (sh_q == {$past(si_i), $past(sh_q[LEN-1:1])}));
endmodule

// File: rtl/tdr_update_stage.sv
module tdr_update_stage
    import tdr_pkg::*;
#(
    parameter int             LEN     = 8,
    parameter logic [LEN-1:0] WR_MASK = 8'h3F,
    parameter logic [LEN-1:0] RST_VAL = 8'h28
) (
    input  logic           tck,
    input  logic           rst_n,
    input  tdr_op_e        op_i,
    input  logic [LEN-1:0] sh_i,
    output logic [LEN-1:0] upd_q
);
    localparam logic [LEN-1:0] RST_EFF = RST_VAL & WR_MASK;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            upd_q <= RST_EFF;
        end else if (op_i == OP_UPDATE) begin
            upd_q <= (sh_i & WR_MASK) | (upd_q & ~WR_MASK);
        end
    end

    p_latch_hold_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (op_i != OP_UPDATE) |=> $stable(upd_q));
endmodule

// File: rtl/tdr_scan_retime.sv
module tdr_scan_retime (
    input  logic tck,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= d_i;
    end
endmodule

// File: rtl/tdr_instr_if.sv
module tdr_instr_if
    import tdr_pkg::*;
#(
    parameter int             LEN     = 8,
    parameter logic [LEN-1:0] WR_MASK = 8'h3F,
    parameter logic [LEN-1:0] RD_MASK = 8'hFC,
    parameter logic [LEN-1:0] RST_VAL = 8'h28
) (
    input  logic           tck,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           capture_en,
    input  logic           shift_en,
    input  logic           update_en,
    input  logic           scan_in,
    output logic           scan_out,
    input  logic [LEN-1:0] resp_in,
    output logic [LEN-1:0] ctrl_out
);
    tdr_op_e        op;
    logic [LEN-1:0] sh_vec;
    logic [LEN-1:0] upd_vec;
    logic [LEN-1:0] cap_vec;

    // Readable bits take the instrument response, the rest their own latch
    assign cap_vec  = (resp_in & RD_MASK) | (upd_vec & ~RD_MASK);
    assign ctrl_out = upd_vec;

    tdr_op_decode u_dec (
        .sel_i (sel),
        .cap_i (capture_en),
        .shf_i (shift_en),
        .upd_i (update_en),
        .op_o  (op)
    );

    tdr_shift_stage #(.LEN(LEN)) u_shf (
        .tck     (tck),
        .rst_n   (rst_n),
        .op_i    (op),
        .si_i    (scan_in),
        .cap_d_i (cap_vec),
        .sh_q    (sh_vec)
    );

    tdr_update_stage #(.LEN(LEN), .WR_MASK(WR_MASK), .RST_VAL(RST_VAL)) u_upd (
        .tck   (tck),
        .rst_n (rst_n),
        .op_i  (op),
        .sh_i  (sh_vec),
        .upd_q (upd_vec)
    );

    tdr_scan_retime u_so (
        .tck   (tck),
        .rst_n (rst_n),
        .d_i   (sh_vec[0]),
        .q_o   (scan_out)
    );

    p_sout_align_r3: assert property (@(posedge tck) disable iff (!rst_n)
        scan_out == sh_vec[0]);

    p_desel_hold_r7: assert property (@(posedge tck) disable iff (!rst_n)
        !sel |=> ($stable(sh_vec) && $stable(ctrl_out)));

    p_multi_hold_r8: assert property (@(posedge tck) disable iff (!rst_n)
        (sel && ($countones({capture_en, shift_en, update_en}) > 1))
        |=> ($stable(sh_vec) && $stable(ctrl_out)));

    p_ro_nolatch_r5: assert property (@(posedge tck) disable iff (!rst_n)
        (ctrl_out & ~WR_MASK) == '0);
endmodule

// File: tb/sim_tdr_instr_if.sv
module sim_tdr_instr_if;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel, cap, shf, upd, si;
    logic [7:0] resp;
    logic       so;
    logic [7:0] ctrl;

    int vectors = 0;
    int fails   = 0;
    string cur  = "R1";

    // reference model state
    logic [7:0] m_sh, m_upd;
    logic       m_so;

    always #4 clk = ~clk;

    tdr_instr_if #(.LEN(8), .WR_MASK(8'h3F), .RD_MASK(8'hFC), .RST_VAL(8'h28)) u0 (
        .tck(clk), .rst_n(rst_n), .sel(sel), .capture_en(cap), .shift_en(shf),
        .update_en(upd), .scan_in(si), .scan_out(so), .resp_in(resp), .ctrl_out(ctrl)
    );

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit rd_bit(input int i); return i >= 2; endfunction
    function automatic bit wr_bit(input int i); return i <= 5; endfunction

    task automatic model_reset();
        m_sh = 8'h00; m_upd = 8'h28; m_so = 1'b0;
    endtask

    // one clock: drive, rising edge, check retime, model, compare after falling edge
    task automatic step(input logic s, input logic c, input logic h, input logic u, input logic d);
        sel = s; cap = c; shf = h; upd = u; si = d;
        @(posedge clk);
        #1;
        check(so === m_so, "R3", {7'd0, so}, {7'd0, m_so});
        if (s && (int'(c) + int'(h) + int'(u)) == 1) begin
            if (c) for (int i = 0; i < 8; i++) m_sh[i] = rd_bit(i) ? resp[i] : m_upd[i];
            if (h) m_sh = {d, m_sh[7:1]};
            if (u) for (int i = 0; i < 8; i++) if (wr_bit(i)) m_upd[i] = m_sh[i];
        end
        #5;
        m_so = m_sh[0];
        check(ctrl === m_upd, cur, ctrl, m_upd);
        check(so === m_so, cur, {7'd0, so}, {7'd0, m_so});
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] got;
        rst_n = 1'b0; sel = 0; cap = 0; shf = 0; upd = 0; si = 0; resp = 8'h00;
        model_reset();
        repeat (3) @(posedge clk);
        #6;
        // R1: reset state
        check(ctrl === 8'h28, "R1", ctrl, 8'h28);
        check(so === 1'b0, "R1", {7'd0, so}, 8'h00);
        rst_n = 1'b1;

        // R2/R4: shift in 0xD7 LSB first, controls unchanged
        cur = "R2";
        for (int k = 0; k < 8; k++) step(1, 0, 1, 0, 1'((8'hD7 >> k) & 1));
        check(ctrl === 8'h28, "R4", ctrl, 8'h28);

        // R5: update, read-only bits stay 0
        cur = "R5";
        step(1, 0, 0, 1, 0);
        check(ctrl === 8'h17, "R5", ctrl, 8'h17);

        // R6: capture response 0xA5, read back through the scan path
        cur = "R6";
        resp = 8'hA5;
        step(1, 1, 0, 0, 0);
        got[0] = so;
        cur = "R4";
        for (int k = 1; k < 8; k++) begin
            step(1, 0, 1, 0, 1'((8'h5A >> (k - 1)) & 1));
            got[k] = so;
        end
        step(1, 0, 1, 0, 1'((8'h5A >> 7) & 1));
        check(got === 8'hA7, "R6", got, 8'hA7);
        check(ctrl === 8'h17, "R4", ctrl, 8'h17);

        // R7: deselected, all enables toggled
        cur = "R7";
        resp = 8'hFF;
        step(0, 0, 1, 1, 1);
        step(0, 1, 0, 0, 1);
        step(0, 0, 0, 1, 0);
        check(ctrl === 8'h17, "R7", ctrl, 8'h17);
        cur = "R5";
        step(1, 0, 0, 1, 0);
        check(ctrl === 8'h1A, "R7", ctrl, 8'h1A);

        // R8: conflicting enables hold everything
        cur = "R8";
        step(1, 1, 1, 0, 1);
        step(1, 0, 1, 1, 1);
        step(1, 1, 1, 1, 1);
        check(ctrl === 8'h1A, "R8", ctrl, 8'h1A);
        step(1, 0, 0, 1, 0);
        check(ctrl === 8'h1A, "R8", ctrl, 8'h1A);

        // R1: asynchronous reset in the middle of activity
        cur = "R2";
        for (int k = 0; k < 4; k++) step(1, 0, 1, 0, 1);
        step(1, 0, 0, 1, 0);
        rst_n = 1'b0;
        #1;
        model_reset();
        check(ctrl === 8'h28, "R1", ctrl, 8'h28);
        check(so === 1'b0, "R1", {7'd0, so}, 8'h00);
        @(posedge clk);
        #6;
        rst_n = 1'b1;
        cur = "R1";
        step(1, 0, 0, 1, 0);
        check(ctrl === 8'h00, "R1", ctrl, 8'h00);

        finish_run();
    end
endmodule